// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit collects the event flags of a byte-oriented serial bus controller into one 16-bit status word and turns them into a single interrupt line and two DMA request lines, one for receive and one for transmit. The other parts of the controller raise flags through one-cycle set pulses. A separate hardware-clear vector lets them drop the two data-ready flags, which software cannot clear.

Software reaches the unit through a simple single-cycle register port. The port has five word registers. There is an enable mask and a status word. A status write clears the bits written as one, and a status read also shows live bus activity. There is a vector register that acknowledges on read, a DMA configuration word, and a self-test word that accepts writes only. A vector read returns the 1-based number of the lowest flag that is both pending and enabled, and it clears that flag. Turning on DMA for one direction also removes the interrupt enable of the matching ready flag, so a ready flag is served by DMA or by interrupt but never by both.

A parameter selects the older or the newer revision behaviour. The choice changes the width of the enable mask and decides whether the self-test write works.

Top module: `irq_event_hub`

## Requirements
- R1: `irq_o` is high exactly when some status bit and the same enable-mask bit are both one.
- R2: `rx_dma_req_o` equals status bit 3 while the receive DMA enable is on, and is low otherwise. `tx_dma_req_o` equals status bit 4 while the transmit DMA enable is on, and is low otherwise.
- R3: A write to the DMA configuration register (address 3) stores only bit 15 (receive enable) and bit 7 (transmit enable). Writing bit 15 as one clears enable-mask bit 3, and writing bit 7 as one clears enable-mask bit 4.
- R4: A read of the vector register (address 2) returns, in the same cycle, the 1-based position of the lowest set bit of status AND mask, or 0 when there is none. A nonzero result clears that status bit at the next clock edge.
- R5: A write to the status register (address 1) clears each of the bits 0, 1, 2 and 5 that is written as one. It changes no other status bit.
- R6: A write to the enable mask (address 0) keeps bits 5:0 in the newer revision (`NEW_REV`=1) and bits 4:0 in the older revision. A mask read returns the stored value.
- R7: A status read returns the status word with bit 12 replaced by the live `bus_busy_i` level.
- R8: In the newer revision, a write to the self-test register (address 4) with bit 11 set forces status bits 5:0 to one. In the older revision that write has no effect on status.
- R9: When a set pulse and any clear (software write, vector acknowledge or hardware clear) reach the same status bit in the same cycle, the bit ends up set.
- R10: Each bit of `hw_clr_i` that is one clears the matching status bit at the next clock edge.
- R11: A synchronous reset clears status, mask and DMA configuration, so all three outputs are low and all register reads return 0. Reads of addresses 4 to 7 always return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 16 | One-cycle set pulses for status bits |
| hw_clr_i | input | 16 | Hardware clear pulses for status bits |
| bus_busy_i | input | 1 | Live bus-busy level shown in status bit 12 |
| acc_en_i | input | 1 | Register access valid this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 3 | Register address |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Read data, combinational in the access cycle |
| irq_o | output | 1 | Interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
The bench sets two enabled flags with a lower flag that is pending but not enabled. A priority encoder that ignores the mask, or counts from zero, then returns the wrong vector, and one that clears the wrong bit leaves stale status behind. It writes all ones to status and expects the ready flags and unlisted bits to survive, which catches a write-one-to-clear mask that is too wide. It drives a set pulse against each kind of clear in the same cycle, where a clear-wins design would lose the event. It also runs an older-revision copy beside the default one, so that a wrong mask width, or a self-test that is not gated by revision, shows up as a read-back mismatch.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    parameter int unsigned WORD_W = 16;
    parameter int unsigned ADDR_W = 3;

    localparam int unsigned VEC_W = $clog2(WORD_W + 1);

    localparam int unsigned RXRDY_BIT    = 3;
    localparam int unsigned TXRDY_BIT    = 4;
    localparam int unsigned BUSY_BIT     = 12;
    localparam int unsigned RXDMA_BIT    = 15;
    localparam int unsigned TXDMA_BIT    = 7;
    localparam int unsigned SELFTEST_BIT = 11;
    localparam int unsigned FORCE_W      = 6;

    localparam logic [WORD_W-1:0] SW_CLR_MASK   = WORD_W'('h0027);
    localparam logic [WORD_W-1:0] MASK_KEEP_NEW = WORD_W'('h003F);
    localparam logic [WORD_W-1:0] MASK_KEEP_OLD = WORD_W'('h001F);

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK = ADDR_W'(0),
        SEL_STAT = ADDR_W'(1),
        SEL_VEC  = ADDR_W'(2),
        SEL_DMA  = ADDR_W'(3),
        SEL_TEST = ADDR_W'(4)
    } reg_sel_e;

    typedef struct packed {
        logic wr_mask;
        logic wr_stat;
        logic wr_dma;
        logic wr_test;
        logic rd_vec;
    } strobe_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } dma_cfg_t;

    function automatic logic [WORD_W-1:0] mask_keep(input bit new_rev);
        return new_rev ? MASK_KEEP_NEW : MASK_KEEP_OLD;
    endfunction

endpackage

// File: rtl/irqv_decode.sv
module irqv_decode
    import irqv_pkg::*;
(
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output strobe_t           strobe
);
    reg_sel_e sel;

    always_comb begin
        sel            = reg_sel_e'(acc_addr);
        strobe         = '0;
        strobe.wr_mask = acc_en &&  acc_wr && (sel == SEL_MASK);
        strobe.wr_stat = acc_en &&  acc_wr && (sel == SEL_STAT);
        strobe.wr_dma  = acc_en &&  acc_wr && (sel == SEL_DMA);
        strobe.wr_test = acc_en &&  acc_wr && (sel == SEL_TEST);
        strobe.rd_vec  = acc_en && !acc_wr && (sel == SEL_VEC);
    end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
(
    input  logic [WORD_W-1:0] pend,
    output logic [WORD_W-1:0] hit,
    output logic [VEC_W-1:0]  index
);
    logic [WORD_W:0] below;

    assign below[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < WORD_W; g++) begin : g_chain
            assign hit[g]     = pend[g] & ~below[g];
            assign below[g+1] = below[g] | pend[g];
        end
    endgenerate

    always_comb begin
        index = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (hit[i]) index = VEC_W'(i + 1);
        end
    end
endmodule

// File: rtl/irqv_enables.sv
module irqv_enables
    import irqv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           strobe,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] mask_q,
    output dma_cfg_t          dma_q
);
    localparam logic [WORD_W-1:0] KEEP = mask_keep(NEW_REV);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            dma_q  <= '0;
        end else if (strobe.wr_mask) begin
            mask_q <= wdata & KEEP;
        end else if (strobe.wr_dma) begin
            dma_q.rx_en <= wdata[RXDMA_BIT];
            dma_q.tx_en <= wdata[TXDMA_BIT];
            if (wdata[RXDMA_BIT]) mask_q[RXRDY_BIT] <= 1'b0;
            if (wdata[TXDMA_BIT]) mask_q[TXRDY_BIT] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqv_status.sv
module irqv_status
    import irqv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] evt_set,
    input  logic [WORD_W-1:0] hw_clr,
    input  strobe_t           strobe,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] ack_hit,
    output logic [WORD_W-1:0] stat_q
);
    logic [WORD_W-1:0] sw_clr;
    logic [WORD_W-1:0] ack_clr;
    logic              force_on;

    assign sw_clr   = strobe.wr_stat ? (wdata & SW_CLR_MASK) : '0;
    assign ack_clr  = strobe.rd_vec ? ack_hit : '0;
    assign force_on = NEW_REV && strobe.wr_test && wdata[SELFTEST_BIT];

    genvar g;
    generate
        for (g = 0; g < WORD_W; g++) begin : g_bit
            logic set_b;
            logic clr_b;
            if (g < FORCE_W) begin : g_forced
                assign set_b = evt_set[g] | force_on;
            end else begin : g_plain
                assign set_b = evt_set[g];
            end
            assign clr_b = hw_clr[g] | sw_clr[g] | ack_clr[g];

            always_ff @(posedge clk) begin
                if (rst)        stat_q[g] <= 1'b0;
                else if (set_b) stat_q[g] <= 1'b1;
                else if (clr_b) stat_q[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_event_hub.sv
module irq_event_hub
    import irqv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] evt_set_i,
    input  logic [WORD_W-1:0] hw_clr_i,
    input  logic              bus_busy_i,
    input  logic              acc_en_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [WORD_W-1:0] acc_wdata_i,
    output logic [WORD_W-1:0] acc_rdata_o,
    output logic              irq_o,
    output logic              rx_dma_req_o,
    output logic              tx_dma_req_o
);
    strobe_t           strobe;
    logic [WORD_W-1:0] mask_q;
    dma_cfg_t          dma_q;
    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] pend;
    logic [WORD_W-1:0] ack_hit;
    logic [VEC_W-1:0]  vec_idx;
    reg_sel_e          rsel;

    irqv_decode u_dec (
        .acc_en   (acc_en_i),
        .acc_wr   (acc_wr_i),
        .acc_addr (acc_addr_i),
        .strobe   (strobe)
    );

    irqv_enables #(.NEW_REV(NEW_REV)) u_en (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .wdata  (acc_wdata_i),
        .mask_q (mask_q),
        .dma_q  (dma_q)
    );

    irqv_status #(.NEW_REV(NEW_REV)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .evt_set (evt_set_i),
        .hw_clr  (hw_clr_i),
        .strobe  (strobe),
        .wdata   (acc_wdata_i),
        .ack_hit (ack_hit),
        .stat_q  (stat_q)
    );

    assign pend = stat_q & mask_q;

    irqv_prio u_prio (
        .pend  (pend),
        .hit   (ack_hit),
        .index (vec_idx)
    );

    assign irq_o        = |pend;
    assign rx_dma_req_o = dma_q.rx_en & stat_q[RXRDY_BIT];
    assign tx_dma_req_o = dma_q.tx_en & stat_q[TXRDY_BIT];

    always_comb begin
        rsel        = reg_sel_e'(acc_addr_i);
        acc_rdata_o = '0;
        if (acc_en_i && !acc_wr_i) begin
            case (rsel)
                SEL_MASK: acc_rdata_o = mask_q;
                SEL_STAT: begin
                    acc_rdata_o           = stat_q;
                    acc_rdata_o[BUSY_BIT] = bus_busy_i;
                end
                SEL_VEC:  acc_rdata_o = WORD_W'(vec_idx);
                SEL_DMA: begin
                    acc_rdata_o[RXDMA_BIT] = dma_q.rx_en;
                    acc_rdata_o[TXDMA_BIT] = dma_q.tx_en;
                end
                default:  acc_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] evt_set_i,
    input logic [WORD_W-1:0] hw_clr_i,
    input logic              acc_en_i,
    input logic              acc_wr_i,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic [WORD_W-1:0] acc_wdata_i,
    input logic [WORD_W-1:0] acc_rdata_o,
    input logic              irq_o,
    input logic              rx_dma_req_o,
    input logic              tx_dma_req_o,
    input logic [WORD_W-1:0] mask_q,
    input logic [WORD_W-1:0] stat_q
);
    logic vec_rd;
    logic stat_wr;
    logic dma_wr;
    logic test_wr;

    assign vec_rd  = acc_en_i && !acc_wr_i && (acc_addr_i == ADDR_W'(2));
    assign stat_wr = acc_en_i &&  acc_wr_i && (acc_addr_i == ADDR_W'(1));
    assign dma_wr  = acc_en_i &&  acc_wr_i && (acc_addr_i == ADDR_W'(3));
    assign test_wr = acc_en_i &&  acc_wr_i && (acc_addr_i == ADDR_W'(4));

    // R1
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask_q != '0));

    // R2
    dma_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_dma_req_o |-> stat_q[RXRDY_BIT]) and (tx_dma_req_o |-> stat_q[TXRDY_BIT]));

    // R3
    dma_drops_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_wr && acc_wdata_i[RXDMA_BIT]) |=> !mask_q[RXRDY_BIT]);

    // R4
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && !irq_o) |-> (acc_rdata_o == '0));

    // R4
    vec_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && acc_rdata_o == WORD_W'(1) && !evt_set_i[0]) |=> !stat_q[0]);

    // R5
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_q[TXRDY_BIT] && !hw_clr_i[TXRDY_BIT] && !vec_rd) |=> stat_q[TXRDY_BIT]);

    // R6
    mask_width_chk: assert property (@(posedge clk) disable iff (rst)
        NEW_REV || !mask_q[5]);

    // R8
    selftest_force_chk: assert property (@(posedge clk) disable iff (rst)
        (NEW_REV && test_wr && acc_wdata_i[SELFTEST_BIT]) |=> (stat_q[5:0] == 6'h3F));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt_set_i[0] |=> stat_q[0]);
endmodule

bind irq_event_hub irqv_checker #(.NEW_REV(NEW_REV)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt_set_i    (evt_set_i),
    .hw_clr_i     (hw_clr_i),
    .acc_en_i     (acc_en_i),
    .acc_wr_i     (acc_wr_i),
    .acc_addr_i   (acc_addr_i),
    .acc_wdata_i  (acc_wdata_i),
    .acc_rdata_o  (acc_rdata_o),
    .irq_o        (irq_o),
    .rx_dma_req_o (rx_dma_req_o),
    .tx_dma_req_o (tx_dma_req_o),
    .mask_q       (mask_q),
    .stat_q       (stat_q)
);

// File: tb/irq_event_hub_tb.sv
module irq_event_hub_tb_top;
    import irqv_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORD_W-1:0] evt_set = '0;
    logic [WORD_W-1:0] hw_clr = '0;
    logic              busy = 1'b0;
    logic              acc_en = 1'b0;
    logic              acc_wr = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [WORD_W-1:0] acc_wdata = '0;
    logic [WORD_W-1:0] rdata, rdata_old;
    logic              irq, rxq, txq, irq_old, rxq_old, txq_old;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irq_event_hub #(.NEW_REV(1'b1)) dut_i (
        .clk(clk), .rst(rst), .evt_set_i(evt_set), .hw_clr_i(hw_clr),
        .bus_busy_i(busy), .acc_en_i(acc_en), .acc_wr_i(acc_wr),
        .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_rdata_o(rdata),
        .irq_o(irq), .rx_dma_req_o(rxq), .tx_dma_req_o(txq)
    );

    irq_event_hub #(.NEW_REV(1'b0)) dut_old_i (
        .clk(clk), .rst(rst), .evt_set_i(evt_set), .hw_clr_i(hw_clr),
        .bus_busy_i(busy), .acc_en_i(acc_en), .acc_wr_i(acc_wr),
        .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_rdata_o(rdata_old),
        .irq_o(irq_old), .rx_dma_req_o(rxq_old), .tx_dma_req_o(txq_old)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // one access cycle; optional set/clear pulses in the same cycle
    task automatic access(input bit wr, input int addr, input int wd,
                          input int evt, input int clr, output int rd, output int rd_old);
        @(negedge clk);
        acc_en    = 1'b1;
        acc_wr    = wr;
        acc_addr  = ADDR_W'(addr);
        acc_wdata = WORD_W'(wd);
        evt_set   = WORD_W'(evt);
        hw_clr    = WORD_W'(clr);
        #1;
        rd     = int'(rdata);
        rd_old = int'(rdata_old);
        @(negedge clk);
        acc_en  = 1'b0;
        acc_wr  = 1'b0;
        evt_set = '0;
        hw_clr  = '0;
    endtask

    task automatic wr(input int addr, input int wd);
        int a, b;
        access(1'b1, addr, wd, 0, 0, a, b);
    endtask

    task automatic rd(input int addr, output int d);
        int b;
        access(1'b0, addr, 0, 0, 0, d, b);
    endtask

    task automatic pulse(input int evt, input int clr);
        @(negedge clk);
        evt_set = WORD_W'(evt);
        hw_clr  = WORD_W'(clr);
        @(negedge clk);
        evt_set = '0;
        hw_clr  = '0;
    endtask

    task automatic t_reset;
        int d;
        pulse(16'h0031, 0);
        wr(0, 16'h003F);
        wr(3, 16'h8080);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!irq && !rxq && !txq, "R11 outputs after reset", {irq, rxq, txq}, 0);
        rd(1, d); chk_eq("R11 status after reset", d, 0);
        rd(0, d); chk_eq("R11 mask after reset", d, 0);
        rd(3, d); chk_eq("R11 dma cfg after reset", d, 0);
        rd(5, d); chk_eq("R11 unused address", d, 0);
    endtask

    task automatic t_irq;
        pulse(16'h0002, 0);
        chk_eq("R1 irq with mask clear", int'(irq), 0);
        wr(0, 16'h0002);
        chk_eq("R1 irq with bit enabled", int'(irq), 1);
        wr(0, 16'h0004);
        chk_eq("R1 irq with other bit enabled", int'(irq), 0);
        wr(0, 0);
        wr(1, 16'h0002);
    endtask

    task automatic t_vec;
        int d;
        pulse(16'h0025, 0);
        wr(0, 16'h0024);
        rd(2, d); chk_eq("R4 first vector", d, 3);
        rd(1, d); chk_eq("R4 status after first ack", d, 16'h0021);
        rd(2, d); chk_eq("R4 second vector", d, 6);
        rd(2, d); chk_eq("R4 vector when none pending", d, 0);
        rd(1, d); chk_eq("R4 unenabled bit kept", d, 16'h0001);
        wr(1, 16'h0001);
        wr(0, 0);
    endtask

    task automatic t_w1c;
        int d;
        pulse(16'h00FF, 0);
        wr(1, 16'hFFFF);
        rd(1, d); chk_eq("R5 write-one-to-clear limited", d, 16'h00D8);
        pulse(0, 16'h00D8);
        rd(1, d); chk_eq("R10 hardware clear", d, 0);
    endtask

    task automatic t_dma;
        int d;
        wr(0, 16'h003F);
        wr(3, 16'hFFFF);
        rd(3, d); chk_eq("R3 dma cfg keeps bits 15,7", d, 16'h8080);
        rd(0, d); chk_eq("R3 mask bits 3,4 dropped", d, 16'h0027);
        chk_eq("R2 rx req idle", int'(rxq), 0);
        pulse(16'h0008, 0);
        check(rxq && !txq, "R2 rx req follows ready", {rxq, txq}, 2'b10);
        chk_eq("R1 irq off with ready bits unmasked", int'(irq), 0);
        pulse(16'h0010, 0);
        chk_eq("R2 tx req follows ready", int'(txq), 1);
        wr(3, 0);
        check(!rxq && !txq, "R2 requests off when disabled", {rxq, txq}, 0);
        pulse(0, 16'h0018);
        wr(0, 0);
    endtask

    task automatic t_mask;
        int d, dold;
        access(1'b1, 0, 16'hFFFF, 0, 0, d, dold);
        access(1'b0, 0, 0, 0, 0, d, dold);
        chk_eq("R6 mask width newer", d, 16'h003F);
        chk_eq("R6 mask width older", dold, 16'h001F);
        wr(0, 0);
    endtask

    task automatic t_busy;
        int d, dold;
        busy = 1'b1;
        access(1'b0, 1, 0, 0, 0, d, dold);
        chk_eq("R7 busy shown", d, 16'h1000);
        busy = 1'b0;
        pulse(16'h1000, 0);
        rd(1, d); chk_eq("R7 stored bit 12 hidden", d, 0);
        pulse(0, 16'h1000);
    endtask

    task automatic t_test;
        int d, dold;
        wr(4, 16'h0800);
        access(1'b0, 1, 0, 0, 0, d, dold);
        chk_eq("R8 self-test forces low bits", d, 16'h003F);
        chk_eq("R8 self-test ignored in older revision", dold, 0);
        wr(4, 16'h0000);
        rd(1, d); chk_eq("R8 no force without bit 11", d, 16'h003F);
        wr(1, 16'h0027);
        pulse(0, 16'h0018);
        rd(1, d); chk_eq("R5 cleanup after self-test", d, 0);
    endtask

    task automatic t_setwins;
        int d, dold;
        access(1'b1, 1, 16'h0001, 16'h0001, 0, d, dold);
        rd(1, d); chk_eq("R9 set beats software clear", d, 16'h0001);
        wr(0, 16'h0001);
        access(1'b0, 2, 0, 16'h0001, 0, d, dold);
        chk_eq("R9 vector during set", d, 1);
        rd(1, d); chk_eq("R9 set beats acknowledge", d, 16'h0001);
        pulse(16'h0001, 16'h0001);
        rd(1, d); chk_eq("R9 set beats hardware clear", d, 16'h0001);
        rd(2, d); chk_eq("R4 ack after contention", d, 1);
        rd(1, d); chk_eq("R4 cleared by ack", d, 0);
        wr(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_irq();
        t_vec();
        t_w1c();
        t_dma();
        t_mask();
        t_busy();
        t_test();
        t_setwins();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule